// File: doc/BRIEF.md
# Dual-Channel Serial DAC Frame Writer

This block pushes a pair of 12-bit samples to two serial digital-to-analog converters that sit on a shared frame-sync line and a shared serial clock. Each converter has its own data line. A one-cycle `load` pulse captures both samples. The block wraps each sample into a 16-bit word whose two power-mode bits select normal output. It then plays out one write sequence: frame-sync goes low, sixteen serial clock cycles follow with data shifted most significant bit first, and frame-sync returns high.

The serial clock comes from the system clock by a divider: each phase of the serial clock lasts `HALF_DIV` system clocks. After a frame, frame-sync is held high for at least `SYNC_HOLD` clocks before the next frame may begin. `busy` covers the whole interval, and `load` pulses that arrive while it is set are dropped. The surrounding logic supplies the samples and decides how often to send them.

With the defaults at 125 MHz, each serial clock phase is 24 ns (48 ns period) and frame-sync stays high for at least 32 ns between frames. One frame occupies `32*HALF_DIV + SYNC_HOLD` clocks, which is 99 clocks.

Top module: `dual_dac_writer`

## Requirements
- R1: During reset and whenever `busy` is low, `frame_sync` is 1, `ser_clk` is 1, and both data outputs are 0. `busy` is 0 after reset.
- R2: Each frame carries, most significant bit first, the 16-bit word {2'b00 pad, 2'b00 normal mode, sample[11:0]}. `dout_a` carries `sample_a` and `dout_b` carries `sample_b`, both captured on the cycle that `load` is accepted.
- R3: The data outputs change only when `frame_sync` falls, on a rising `ser_clk`, or at the end of a frame. They never change on the cycle that `ser_clk` falls.
- R4: While `frame_sync` is low, every high and every low phase of `ser_clk` lasts exactly `HALF_DIV` system clocks, including the first high phase after `frame_sync` falls.
- R5: The first falling edge of `ser_clk` comes `HALF_DIV` clocks after `frame_sync` falls, with the most significant bit already on the data lines.
- R6: Each frame has exactly 16 falling edges of `ser_clk`. `frame_sync` rises together with the rising `ser_clk` that follows the 16th falling edge, so `ser_clk` is high when `frame_sync` rises.
- R7: Between back-to-back frames, `frame_sync` stays high for `SYNC_HOLD + 1` clocks.
- R8: `busy` rises on the cycle after an accepted `load` and stays high for `32*HALF_DIV + SYNC_HOLD` clocks.
- R9: A `load` that arrives while `busy` is high has no effect. The frame in flight keeps its data, and no extra frame follows.
- R10: Reset in the middle of a frame returns all outputs to the idle levels of R1. The converters see fewer than 16 falling edges, so the partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | One-cycle request to send the two samples |
| sample_a | input | 12 | Sample for the first converter |
| sample_b | input | 12 | Sample for the second converter |
| frame_sync | output | 1 | Shared frame-sync line, active low during a frame |
| ser_clk | output | 1 | Shared serial clock; data is taken on its falling edge |
| dout_a | output | 1 | Serial data to the first converter |
| dout_b | output | 1 | Serial data to the second converter |
| busy | output | 1 | High from the accepted load until the sync high time ends |

## Verification
The bench rebuilds both 16-bit words the way a converter would, sampling on each falling serial clock edge. It compares them with the samples it sent, so a swapped channel, a wrong mode field or least-significant-first order shows up as a word mismatch. It measures every serial clock phase and the gap between back-to-back frames. A divider that is off by one, or a sync gap cut short, shows up as a wrong run length. Data that moved on a falling edge is counted as a hold violation. A `load` issued mid-frame must leave the captured word and the frame count unchanged. A reset in the middle of a frame must return the lines to idle without a seventeenth edge or a completed word.

// File: rtl/dac_writer_pkg.sv
// Shared definitions for the dual DAC writer.
// Holds the frame geometry, the sequencer state type and the frame builder.
// Assumes a 16-bit converter word: pad bits, mode bits, then the sample.
package dac_writer_pkg;

    localparam int SAMPLE_W = 12;
    localparam int MODE_W   = 2;
    localparam int FRAME_W  = 16;
    localparam int PAD_W    = FRAME_W - MODE_W - SAMPLE_W;

    localparam logic [MODE_W-1:0] MODE_NORMAL = '0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } wr_state_t;

    // Wrap a sample into a converter word in normal output mode.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [SAMPLE_W-1:0] s);
        return {{PAD_W{1'b0}}, MODE_NORMAL, s};
    endfunction

endpackage

// File: rtl/dac_sclk_gen.sv
// Serial clock divider.
// While run is high, the serial clock toggles every HALF_DIV system clocks,
// starting from the high level. rise and fall flag the cycle whose clock
// edge makes the toggle. While run is low the clock parks high.
// Assumes HALF_DIV >= 1.
module dac_sclk_gen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);

    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] phase_cnt;
    logic          sclk_q;
    logic          terminal;

    assign terminal = run && (phase_cnt == CW'(HALF_DIV - 1));
    assign rise     = terminal && !sclk_q;
    assign fall     = terminal &&  sclk_q;
    assign sclk     = sclk_q;

    // Count the phase length and toggle the serial clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            sclk_q    <= 1'b1;
        end else if (terminal) begin
            phase_cnt <= '0;
            sclk_q    <= !sclk_q;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R4: the clock cannot move while a phase is still being counted.
    a_r4_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !terminal) |=> (sclk == $past(sclk)));

endmodule

// File: rtl/dac_frame_ctrl.sv
// Frame sequencer.
// Accepts a load only when idle and counts falling serial clock edges.
// The frame ends on the rising edge after the last one. Frame-sync is then
// held high for SYNC_HOLD clocks, and the block goes idle again.
// Assumes FRAME_W >= 1 and SYNC_HOLD >= 1.
module dac_frame_ctrl
    import dac_writer_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SYNC_HOLD  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rise,
    input  logic fall,
    output logic start,
    output logic shift,
    output logic done,
    output logic run,
    output logic busy,
    output logic sync
);

    localparam int FCW = $clog2(FRAME_BITS + 1);
    localparam int HCW = $clog2(SYNC_HOLD + 1);

    wr_state_t      state;
    logic [FCW-1:0] fall_cnt;
    logic [HCW-1:0] hold_cnt;
    logic           last_bit;

    assign last_bit = (fall_cnt == FCW'(FRAME_BITS));
    assign start    = (state == ST_IDLE) && load;
    assign done     = rise && last_bit;
    assign shift    = rise && !last_bit;
    assign run      = (state == ST_SHIFT);
    assign busy     = (state != ST_IDLE);

    // Step through idle, shifting and the sync high hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fall_cnt <= '0;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    fall_cnt <= '0;
                    if (load) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fall) fall_cnt <= fall_cnt + 1'b1;
                    if (done) begin
                        state    <= ST_HOLD;
                        hold_cnt <= '0;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == HCW'(SYNC_HOLD - 1)) state <= ST_IDLE;
                    else                                 hold_cnt <= hold_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive frame-sync low for the frame and high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     sync <= 1'b1;
        else if (start) sync <= 1'b0;
        else if (done)  sync <= 1'b1;
    end

    // R6: no falling edge beyond the last bit of the word.
    a_r6_fall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (fall_cnt < FCW'(FRAME_BITS)));

    // R9: the hold phase never restarts a frame directly.
    a_r9_hold_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state != ST_SHIFT));

    // R7: frame-sync is high throughout the hold.
    a_r7_sync_high_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> sync);

endmodule

// File: rtl/dac_chan_shifter.sv
// One channel's output shift register.
// Loads a full word on start and moves it one bit toward the MSB on each
// shift. It clears on done, so the line idles low. The output is the MSB.
// Assumes start, shift and done are mutually exclusive.
module dac_chan_shifter #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  shift,
    input  logic                  done,
    input  logic [FRAME_BITS-1:0] word_in,
    output logic                  dout
);

    logic [FRAME_BITS-1:0] sreg;

    assign dout = sreg[FRAME_BITS-1];

    // Hold, load, advance or clear the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n || done) sreg <= '0;
        else if (start)     sreg <= word_in;
        else if (shift)     sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
    end

endmodule

// File: rtl/dual_dac_writer.sv
// Dual-channel serial DAC writer, top level.
// Captures two samples on load and sends them in lockstep to two converters
// that share frame-sync and the serial clock. The serial clock is divided
// from clk by HALF_DIV per phase. Frame-sync is kept high SYNC_HOLD clocks
// between frames. Assumes HALF_DIV and SYNC_HOLD are chosen so the converter
// timing minimums hold at the system clock rate.
module dual_dac_writer
    import dac_writer_pkg::*;
#(
    parameter int HALF_DIV  = 3,
    parameter int SYNC_HOLD = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample_a,
    input  logic [SAMPLE_W-1:0] sample_b,
    output logic                frame_sync,
    output logic                ser_clk,
    output logic                dout_a,
    output logic                dout_b,
    output logic                busy
);

    localparam int NUM_CH = 2;

    logic start, shift, done, run, rise, fall;
    logic [NUM_CH-1:0][FRAME_W-1:0] words;
    logic [NUM_CH-1:0]              douts;

    // Build both words from the raw samples.
    always_comb begin
        words[0] = build_frame(sample_a);
        words[1] = build_frame(sample_b);
    end

    dac_frame_ctrl #(
        .FRAME_BITS (FRAME_W),
        .SYNC_HOLD  (SYNC_HOLD)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .rise  (rise),
        .fall  (fall),
        .start (start),
        .shift (shift),
        .done  (done),
        .run   (run),
        .busy  (busy),
        .sync  (frame_sync)
    );

    dac_sclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sclk  (ser_clk),
        .rise  (rise),
        .fall  (fall)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dac_chan_shifter #(
            .FRAME_BITS (FRAME_W)
        ) u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .shift   (shift),
            .done    (done),
            .word_in (words[ch]),
            .dout    (douts[ch])
        );
    end

    assign dout_a = douts[0];
    assign dout_b = douts[1];

    // R1: idle lines whenever no frame is pending.
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (frame_sync && ser_clk && !dout_a && !dout_b));

    // R3: data is held across every falling serial clock edge.
    a_r3_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> ($stable(dout_a) && $stable(dout_b)));

    // R6: frame-sync rises only with the serial clock high.
    a_r6_sclk_high_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_sync) |-> ser_clk);

    // R8: frame-sync is never low outside a busy interval.
    a_r8_sync_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |-> busy);

endmodule

// File: tb/sim_dual_dac_writer.sv
module sim_dual_dac_writer;

    localparam int H = 3;
    localparam int S = 3;
    localparam int BUSY_LEN = 32 * H + S;
    localparam int NV = 6;
    localparam logic [23:0] VEC [0:NV-1] = '{
        24'h000_000, 24'hFFF_FFF, 24'h800_7FF,
        24'hA5A_5A5, 24'h001_FFE, 24'h3C9_6B0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [11:0] sample_a = '0, sample_b = '0;
    logic frame_sync, ser_clk, dout_a, dout_b, busy;

    int checks = 0;
    int failures = 0;

    always #4 clk = !clk;

    dual_dac_writer #(.HALF_DIV(H), .SYNC_HOLD(S)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load),
        .sample_a(sample_a), .sample_b(sample_b),
        .frame_sync(frame_sync), .ser_clk(ser_clk),
        .dout_a(dout_a), .dout_b(dout_b), .busy(busy)
    );

    // Converter-side monitor, sampled on the falling system clock edge.
    int bitcnt = 0, frames = 0, falls_last = 0, viol = 0;
    int run_len = 0, run_min = 1000, run_max = 0;
    int sync_hi = 0, last_gap = 0, busy_run = 0, last_busy = 0;
    logic [15:0] sh_a = '0, sh_b = '0, cap_a = '0, cap_b = '0;
    logic p_sync = 1'b1, p_sclk = 1'b1, p_da = 1'b0, p_db = 1'b0, p_busy = 1'b0;

    always @(negedge clk) begin
        if (frame_sync) begin
            if (!p_sync) begin
                falls_last = bitcnt;
                if (rst_n && !p_sclk && ser_clk) begin
                    if (run_len < run_min) run_min = run_len;
                    if (run_len > run_max) run_max = run_len;
                end
            end
            bitcnt = 0;
            sync_hi++;
        end else begin
            if (p_sync) begin
                last_gap = sync_hi;
                run_len = 1;
            end else if (ser_clk != p_sclk) begin
                if (run_len < run_min) run_min = run_len;
                if (run_len > run_max) run_max = run_len;
                run_len = 1;
            end else begin
                run_len++;
            end
            sync_hi = 0;
            if (p_sclk && !ser_clk) begin
                if (dout_a != p_da || dout_b != p_db) viol++;
                sh_a = {sh_a[14:0], dout_a};
                sh_b = {sh_b[14:0], dout_b};
                bitcnt++;
                if (bitcnt == 16) begin
                    frames++;
                    cap_a = sh_a;
                    cap_b = sh_b;
                end
            end
        end
        if (busy) busy_run++;
        else begin
            if (p_busy) last_busy = busy_run;
            busy_run = 0;
        end
        p_sync = frame_sync; p_sclk = ser_clk; p_da = dout_a; p_db = dout_b; p_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [11:0] a, input logic [11:0] b);
        @(negedge clk);
        sample_a = a; sample_b = b; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        chk(frame_sync == 1'b1, {tag, " sync"}, int'(frame_sync), 1);
        chk(ser_clk == 1'b1, {tag, " sclk"}, int'(ser_clk), 1);
        chk(dout_a == 1'b0 && dout_b == 1'b0, {tag, " data"}, int'({dout_a, dout_b}), 0);
        chk(busy == 1'b0, {tag, " busy"}, int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0;
        int gap_seen;
        repeat (4) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1 after reset");

        // Table walk: R2 word contents, R6 edge count, R8 busy length.
        for (int i = 0; i < NV; i++) begin
            f0 = frames;
            pulse_load(VEC[i][23:12], VEC[i][11:0]);
            wait_idle();
            chk(cap_a == {4'h0, VEC[i][23:12]}, "R2 word a", int'(cap_a), int'({4'h0, VEC[i][23:12]}));
            chk(cap_b == {4'h0, VEC[i][11:0]}, "R2 word b", int'(cap_b), int'({4'h0, VEC[i][11:0]}));
            chk(frames == f0 + 1 && falls_last == 16, "R6 sixteen falls", falls_last, 16);
            chk(last_busy == BUSY_LEN, "R8 busy length", last_busy, BUSY_LEN);
            check_idle("R1 between frames");
        end
        chk(run_min == H && run_max == H, "R4 phase min", run_min, H);
        chk(run_max == H, "R5 lead and phase max", run_max, H);
        chk(viol == 0, "R3 data held at falling edge", viol, 0);

        // R9: load during a frame is ignored.
        f0 = frames;
        pulse_load(12'h123, 12'h456);
        repeat (30) @(negedge clk);
        pulse_load(12'hEEE, 12'hDDD);
        wait_idle();
        chk(cap_a == 16'h0123 && cap_b == 16'h0456, "R9 word kept", int'(cap_a), 'h0123);
        chk(frames == f0 + 1, "R9 one frame", frames - f0, 1);
        repeat (20) @(negedge clk);
        chk(frames == f0 + 1 && busy == 1'b0 && frame_sync == 1'b1, "R9 no late frame", frames - f0, 1);

        // R7: back-to-back frames with load held high.
        f0 = frames;
        @(negedge clk);
        sample_a = 12'h9AB; sample_b = 12'h0CD; load = 1'b1;
        while (frames < f0 + 2) @(negedge clk);
        gap_seen = last_gap;
        load = 1'b0;
        wait_idle();
        chk(gap_seen == S + 1, "R7 sync gap", gap_seen, S + 1);
        chk(cap_a == 16'h09AB && cap_b == 16'h00CD, "R2 back-to-back word", int'(cap_a), 'h09AB);

        // R10: reset in the middle of a frame.
        f0 = frames;
        pulse_load(12'h777, 12'h888);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("R10 mid-frame reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(frames == f0 && falls_last < 16, "R10 partial discarded", falls_last, 0);
        pulse_load(12'h5C3, 12'hA3C);
        wait_idle();
        chk(cap_a == 16'h05C3 && cap_b == 16'h0A3C, "R10 recovery word", int'(cap_a), 'h05C3);
        chk(viol == 0, "R3 final hold count", viol, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule